// File: doc/BRIEF.md
# Paired-Register Atomic Compare-and-Swap Unit

This unit carries out one atomic compare-and-swap for a small integer core. The core hands it a width code, a 32-bit-mode flag, the destination/compare register index, the swap-value register index and an already computed effective address, then pulses `start`. The unit reads its operands through two register-file read ports. It reads the memory location under a lock and writes the swap value back only when memory matches the compare value. It returns the prior memory contents to the destination register and finishes with a one-cycle `done`.

Operands wider than one register travel in an even/odd register pair. The even register holds the low half and the next register holds the high half. A pair based at index 0 reads as zero, and a destination of index 0 discards the result. Reserved encodings and misaligned addresses are reported on `done` without any memory or register side effect. The memory port is a single-beat request/acknowledge port, 128 bits wide, with data packed into the low bytes.

Top module: `cas_pair_unit`

## Requirements
- R1: `width_code` selects the operand size: 2'b00 is 4 bytes, 2'b01 is 8 bytes, 2'b10 is 16 bytes, and 2'b11 is an illegal encoding. Memory bytes outside the selected size are never changed.
- R2: The 8-byte form uses a register pair when `mode32`=1 and a single register when `mode32`=0. The 16-byte form always uses a pair and is illegal when `mode32`=1.
- R3: When a pair is used, an odd `rd_idx` or `rs2_idx` is illegal. Any illegal encoding raises `err_illegal` with `done` and makes no memory request and no register write.
- R4: A pair or single operand whose index is 0 reads as all zeros, whatever the register file returns for that index.
- R5: For a pair, the low half comes from (and is written to) the even index, and the high half comes from (and is written to) index+1. The low half is written first, in consecutive cycles.
- R6: The address must be a multiple of the operand size, or `err_misalign` is raised with `done` and nothing is accessed. An illegal encoding takes priority, so both flags are never set together.
- R7: The swap value is written to memory only when the selected bytes of memory equal the compare value. The prior memory value is returned in both the equal and the unequal case.
- R8: With `rd_idx`=0, no register write occurs for either half.
- R9: A 32-bit value written back, whether a pair half in 32-bit mode or a 4-byte result, is sign-extended to the register width. The 8-byte single-register result is written unchanged.
- R10: `mem_lock` is held continuously from the read request through the write, and a write is only issued under the lock. An unequal compare releases the lock with no write.
- R11: `done` lasts one cycle, and the error flags are only high with it. A fault completes 2 cycles after `start` is sampled. A legal operation completes after 5 cycles, plus 1 if the swap is written, plus 2 if a pair is used, given a same-cycle memory acknowledge.
- R12: During and after reset `done`, `rf_we`, `mem_req` and `mem_lock` are low. A reset in mid-operation abandons it with no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; the other request inputs are sampled with it |
| width_code | input | 2 | Operand size code |
| mode32 | input | 1 | 1: core runs with 32-bit registers |
| rd_idx | input | RIDX_W | Compare/destination register index |
| rs2_idx | input | RIDX_W | Swap-value register index |
| addr | input | ADDR_W | Effective address |
| rf_raddr_a | output | RIDX_W | Read port A index (compare operand) |
| rf_rdata_a | input | XLEN | Read port A data |
| rf_raddr_b | output | RIDX_W | Read port B index (swap operand) |
| rf_rdata_b | input | XLEN | Read port B data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RIDX_W | Register write index |
| rf_wdata | output | XLEN | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_lock | output | 1 | Location locked against other requesters |
| mem_addr | output | ADDR_W | Memory address |
| mem_size | output | 2 | Access size, same encoding as `width_code` |
| mem_wdata | output | 2*XLEN | Write data in the low bytes |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 2*XLEN | Read data in the low bytes |
| done | output | 1 | Operation finished (one cycle) |
| err_illegal | output | 1 | Reserved encoding, valid with `done` |
| err_misalign | output | 1 | Misaligned address, valid with `done` |

## Verification
Each result has a fixed due cycle counted from the clock edge that samples `start`. Fault flags are due 2 cycles later, and a legal operation is due 5 cycles later, with one more when the swap is written and two more for a pair. The bench derives that count from its own model of the compare outcome. It counts clock edges until `done`, sampling on the falling edge, and checks the count against the expected value. Register and memory writes are applied to the bench models on the falling edge of the cycle that issues them, so the final images are compared after `done`. A mid-operation reset is checked on the falling edge of the cycle after the reset is applied.

// File: rtl/cas_pkg.sv
// Package: shared encodings for the paired-register compare-and-swap unit.
// Assumes the width code encoding is fixed by the instruction decoder.
package cas_pkg;

    typedef enum logic [1:0] {
        WC_WORD = 2'b00,
        WC_DBL  = 2'b01,
        WC_QUAD = 2'b10,
        WC_BAD  = 2'b11
    } width_code_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEC,
        ST_FAULT,
        ST_RDLO,
        ST_RDHI,
        ST_MRD,
        ST_MWR,
        ST_WBLO,
        ST_WBHI,
        ST_DONE
    } cas_state_e;

endpackage

// File: rtl/cas_decode.sv
// Module: cas_decode
// Classifies a latched request: pair usage, reserved encodings and alignment.
// Assumes only the four low address bits matter for alignment (max 16 bytes).
module cas_decode
    import cas_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  logic [1:0]        code,
    input  logic              mode32,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [RIDX_W-1:0] rs2_idx,
    input  logic [3:0]        addr_lo,
    output logic              use_pair,
    output logic              illegal,
    output logic              misalign
);

    logic low_bits_set;

    // Pair usage and reserved-encoding detection.
    always_comb begin
        use_pair = (code == WC_QUAD) || (code == WC_DBL && mode32);
        illegal  = (code == WC_BAD)
                 || (code == WC_QUAD && mode32)
                 || (use_pair && (rd_idx[0] || rs2_idx[0]));
    end

    // Natural alignment test per operand size; illegal takes priority.
    always_comb begin
        unique case (code)
            WC_WORD: low_bits_set = |addr_lo[1:0];
            WC_DBL:  low_bits_set = |addr_lo[2:0];
            WC_QUAD: low_bits_set = |addr_lo[3:0];
            default: low_bits_set = 1'b0;
        endcase
        misalign = !illegal && low_bits_set;
    end

endmodule

// File: rtl/cas_operand.sv
// Module: cas_operand
// Builds the packed compare and swap values from captured register halves,
// masks memory read data to the operand size and compares.
// Assumes XLEN >= 64 so a 32-bit pair fits in the low 64 bits of the operand.
module cas_operand
    import cas_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int OPW = 2 * XLEN,
    localparam int LANES = OPW / 8
) (
    input  logic [1:0]      code,
    input  logic            mode32,
    input  logic            use_pair,
    input  logic [XLEN-1:0] cmp_lo,
    input  logic [XLEN-1:0] cmp_hi,
    input  logic [XLEN-1:0] swp_lo,
    input  logic [XLEN-1:0] swp_hi,
    input  logic [OPW-1:0]  mem_rdata,
    output logic [OPW-1:0]  cmp_val,
    output logic [OPW-1:0]  swp_val,
    output logic [OPW-1:0]  old_val,
    output logic            match
);

    logic [7:0]     nbytes;
    logic [OPW-1:0] mask;
    logic [OPW-1:0] cmp_raw;
    logic [OPW-1:0] swp_raw;

    // Operand size in bytes from the width code.
    always_comb begin
        unique case (code)
            WC_WORD: nbytes = 8'd4;
            WC_DBL:  nbytes = 8'd8;
            WC_QUAD: nbytes = 8'd16;
            default: nbytes = 8'd0;
        endcase
    end

    // One byte-lane enable per lane of the memory beat.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign mask[8*b +: 8] = {8{8'(b) < nbytes}};
    end

    // Pack the register halves into a memory-ordered operand.
    always_comb begin
        if (!use_pair) begin
            cmp_raw = {{XLEN{1'b0}}, cmp_lo};
            swp_raw = {{XLEN{1'b0}}, swp_lo};
        end else if (mode32) begin
            cmp_raw = {{(OPW-64){1'b0}}, cmp_hi[31:0], cmp_lo[31:0]};
            swp_raw = {{(OPW-64){1'b0}}, swp_hi[31:0], swp_lo[31:0]};
        end else begin
            cmp_raw = {cmp_hi, cmp_lo};
            swp_raw = {swp_hi, swp_lo};
        end
    end

    // Size masking and the equality test.
    always_comb begin
        cmp_val = cmp_raw & mask;
        swp_val = swp_raw & mask;
        old_val = mem_rdata & mask;
        match   = (old_val == cmp_val);
    end

endmodule

// File: rtl/cas_writeback.sv
// Module: cas_writeback
// Selects and formats one register's worth of the prior memory value.
// Assumes XLEN >= 64; 32-bit results are sign-extended to XLEN.
module cas_writeback
    import cas_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int OPW = 2 * XLEN
) (
    input  logic [1:0]      code,
    input  logic            mode32,
    input  logic            use_pair,
    input  logic            sel_hi,
    input  logic [OPW-1:0]  old_val,
    output logic [XLEN-1:0] wdata
);

    function automatic logic [XLEN-1:0] sext32(input logic [31:0] v);
        return {{(XLEN-32){v[31]}}, v};
    endfunction

    // Half selection and sign extension for the register write.
    always_comb begin
        if (use_pair && mode32) begin
            wdata = sel_hi ? sext32(old_val[63:32]) : sext32(old_val[31:0]);
        end else if (use_pair) begin
            wdata = sel_hi ? old_val[OPW-1:XLEN] : old_val[XLEN-1:0];
        end else if (code == WC_WORD) begin
            wdata = sext32(old_val[31:0]);
        end else begin
            wdata = old_val[XLEN-1:0];
        end
    end

endmodule

// File: rtl/cas_pair_unit.sv
// Module: cas_pair_unit (top)
// Sequences one atomic compare-and-swap: decode, operand reads (two cycles
// for pairs), locked read, conditional write, register writeback, done.
// Assumes a register file with two combinational read ports and one write
// port, and a memory that holds mem_req stable until mem_ack.
module cas_pair_unit
    import cas_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int ADDR_W = 32,
    localparam int RIDX_W = $clog2(NREG),
    localparam int OPW    = 2 * XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        width_code,
    input  logic              mode32,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [RIDX_W-1:0] rs2_idx,
    input  logic [ADDR_W-1:0] addr,
    output logic [RIDX_W-1:0] rf_raddr_a,
    input  logic [XLEN-1:0]   rf_rdata_a,
    output logic [RIDX_W-1:0] rf_raddr_b,
    input  logic [XLEN-1:0]   rf_rdata_b,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [OPW-1:0]    mem_wdata,
    input  logic              mem_ack,
    input  logic [OPW-1:0]    mem_rdata,
    output logic              done,
    output logic              err_illegal,
    output logic              err_misalign
);

    cas_state_e        state_q, state_d;
    logic [1:0]        code_q;
    logic              mode32_q;
    logic [RIDX_W-1:0] rd_q, rs2_q;
    logic [ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]   cmp_lo_q, cmp_hi_q, swp_lo_q, swp_hi_q;
    logic [OPW-1:0]    old_q;
    logic              ill_q, mis_q;

    logic              use_pair, illegal, misalign, match;
    logic [OPW-1:0]    cmp_val, swp_val, old_val;
    logic [RIDX_W-1:0] rd_hi, rs2_hi;
    logic              rd_zero, rs2_zero;

    assign rd_hi    = {rd_q[RIDX_W-1:1], 1'b1};
    assign rs2_hi   = {rs2_q[RIDX_W-1:1], 1'b1};
    assign rd_zero  = (rd_q == '0);
    assign rs2_zero = (rs2_q == '0);

    cas_decode #(.RIDX_W(RIDX_W)) u_decode (
        .code     (code_q),
        .mode32   (mode32_q),
        .rd_idx   (rd_q),
        .rs2_idx  (rs2_q),
        .addr_lo  (addr_q[3:0]),
        .use_pair (use_pair),
        .illegal  (illegal),
        .misalign (misalign)
    );

    cas_operand #(.XLEN(XLEN)) u_operand (
        .code      (code_q),
        .mode32    (mode32_q),
        .use_pair  (use_pair),
        .cmp_lo    (cmp_lo_q),
        .cmp_hi    (cmp_hi_q),
        .swp_lo    (swp_lo_q),
        .swp_hi    (swp_hi_q),
        .mem_rdata (mem_rdata),
        .cmp_val   (cmp_val),
        .swp_val   (swp_val),
        .old_val   (old_val),
        .match     (match)
    );

    cas_writeback #(.XLEN(XLEN)) u_writeback (
        .code     (code_q),
        .mode32   (mode32_q),
        .use_pair (use_pair),
        .sel_hi   (state_q == ST_WBHI),
        .old_val  (old_q),
        .wdata    (rf_wdata)
    );

    // Next-state sequencing of the operation.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_DEC;
            ST_DEC:   state_d = (illegal || misalign) ? ST_FAULT : ST_RDLO;
            ST_FAULT: state_d = ST_IDLE;
            ST_RDLO:  state_d = use_pair ? ST_RDHI : ST_MRD;
            ST_RDHI:  state_d = ST_MRD;
            ST_MRD:   if (mem_ack) state_d = match ? ST_MWR : ST_WBLO;
            ST_MWR:   if (mem_ack) state_d = ST_WBLO;
            ST_WBLO:  state_d = use_pair ? ST_WBHI : ST_DONE;
            ST_WBHI:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, fault flags, operand halves and prior memory value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            mode32_q <= 1'b0;
            rd_q     <= '0;
            rs2_q    <= '0;
            addr_q   <= '0;
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
            swp_lo_q <= '0;
            swp_hi_q <= '0;
            old_q    <= '0;
            ill_q    <= 1'b0;
            mis_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    code_q   <= width_code;
                    mode32_q <= mode32;
                    rd_q     <= rd_idx;
                    rs2_q    <= rs2_idx;
                    addr_q   <= addr;
                end
                ST_DEC: begin
                    ill_q <= illegal;
                    mis_q <= misalign;
                end
                ST_RDLO: begin
                    cmp_lo_q <= rd_zero  ? '0 : rf_rdata_a;
                    swp_lo_q <= rs2_zero ? '0 : rf_rdata_b;
                    cmp_hi_q <= '0;
                    swp_hi_q <= '0;
                end
                ST_RDHI: begin
                    cmp_hi_q <= rd_zero  ? '0 : rf_rdata_a;
                    swp_hi_q <= rs2_zero ? '0 : rf_rdata_b;
                end
                ST_MRD: if (mem_ack) old_q <= old_val;
                default: ;
            endcase
        end
    end

    // Register-file port drive.
    always_comb begin
        rf_raddr_a = (state_q == ST_RDHI) ? rd_hi  : rd_q;
        rf_raddr_b = (state_q == ST_RDHI) ? rs2_hi : rs2_q;
        rf_we      = ((state_q == ST_WBLO) || (state_q == ST_WBHI)) && !rd_zero;
        rf_waddr   = (state_q == ST_WBHI) ? rd_hi : rd_q;
    end

    // Memory port drive; the lock spans both memory states.
    always_comb begin
        mem_req   = (state_q == ST_MRD) || (state_q == ST_MWR);
        mem_we    = (state_q == ST_MWR);
        mem_lock  = mem_req;
        mem_addr  = addr_q;
        mem_size  = code_q;
        mem_wdata = swp_val;
    end

    // Completion and fault reporting.
    always_comb begin
        done         = (state_q == ST_DONE) || (state_q == ST_FAULT);
        err_illegal  = (state_q == ST_FAULT) && ill_q;
        err_misalign = (state_q == ST_FAULT) && mis_q;
    end

endmodule

// File: rtl/cas_pair_unit_chk.sv
// Module: cas_pair_unit_chk
// Port-level protocol properties of cas_pair_unit, bound to every instance.
module cas_pair_unit_chk #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rf_we,
    input logic [RIDX_W-1:0] rf_waddr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              err_illegal,
    input logic              err_misalign
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_illegal || err_misalign) |-> done); // R11

    AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_illegal && err_misalign)); // R6

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_illegal || err_misalign) |-> (!rf_we && !mem_req && !$past(mem_req))); // R3

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_lock && $past(mem_lock))); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != '0)); // R8

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(rf_we)) |->
            (!$past(rf_waddr[0]) && rf_waddr == RIDX_W'($past(rf_waddr) + 1'b1))); // R5

endmodule

bind cas_pair_unit cas_pair_unit_chk #(
    .XLEN   (XLEN),
    .RIDX_W (RIDX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rf_we        (rf_we),
    .rf_waddr     (rf_waddr),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_lock     (mem_lock),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .done         (done),
    .err_illegal  (err_illegal),
    .err_misalign (err_misalign)
);

// File: tb/cas_pair_unit_tb.sv
module cas_pair_unit_tb;

    localparam int XLEN = 64;
    localparam int OPW  = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    logic        start = 1'b0;
    logic [1:0]  width_code = 2'b00;
    logic        mode32 = 1'b0;
    logic [4:0]  rd_idx = '0, rs2_idx = '0;
    logic [31:0] addr = '0;
    logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
    logic [63:0] rf_rdata_a, rf_rdata_b, rf_wdata;
    logic        rf_we, mem_req, mem_we, mem_lock, mem_ack;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [OPW-1:0] mem_wdata, mem_rdata;
    logic        done, err_illegal, err_misalign;

    logic [63:0] rf_m [32];
    logic [7:0]  mem_m [64];

    int checks = 0;
    int errors = 0;
    int acc_cnt, wr_rf_cnt, lock_bad;

    assign rf_rdata_a = rf_m[rf_raddr_a];
    assign rf_rdata_b = rf_m[rf_raddr_b];
    assign mem_ack    = mem_req;

    function automatic int size_of(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : (c == 2'd2) ? 16 : 0;
    endfunction

    // Combinational memory read: low bytes of the beat, rest zero.
    always_comb begin
        mem_rdata = '0;
        for (int i = 0; i < 16; i++)
            if (i < size_of(mem_size))
                mem_rdata[8*i +: 8] = mem_m[(int'(mem_addr[5:0]) + i) % 64];
    end

    cas_pair_unit u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < 32; i++)
            rf_m[i] = {32'(i * 32'h9E3779B1 + 32'h8000_0001), 32'((i * 32'h85EBCA6B) ^ 32'hF0F0_0F0F)};
        for (int k = 0; k < 64; k++)
            mem_m[k] = 8'(k * 37 + 11);
    endtask

    function automatic logic [127:0] opnd(input int idx, input logic [1:0] c,
                                          input bit m32, input bit pair);
        if (idx == 0) return '0;                                    // R4
        if (pair && m32) return {64'b0, rf_m[idx+1][31:0], rf_m[idx][31:0]}; // R5
        if (pair) return {rf_m[idx+1], rf_m[idx]};
        if (c == 2'd0) return {96'b0, rf_m[idx][31:0]};
        return {64'b0, rf_m[idx]};
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Apply the side effects the DUT issues in the current cycle.
    task automatic apply_effects();
        if (rf_we) begin
            rf_m[rf_waddr] = rf_wdata;
            wr_rf_cnt++;
        end
        if (mem_req) begin
            acc_cnt++;
            if (mem_we) begin
                if (!mem_lock) lock_bad++;
                for (int i = 0; i < size_of(mem_size); i++)
                    mem_m[(int'(mem_addr[5:0]) + i) % 64] = mem_wdata[8*i +: 8];
            end
        end
    endtask

    task automatic run_case(input logic [1:0] c, input bit m32, input int rd,
                            input int rs2, input int a, input bit force_match);
        bit pair, legal, aligned, hit, got, ill_s, mis_s;
        int nb, n, lat_exp, bad_b, bad_r;
        logic [127:0] cmpv, swpv, oldv;
        logic [7:0]  exp_mem [64];
        logic [63:0] exp_rf [32];
        logic [63:0] x0_before;
        preload();
        x0_before = rf_m[0];
        pair    = (c == 2'd2) || (c == 2'd1 && m32);                   // R2
        legal   = (c != 2'd3) && !(c == 2'd2 && m32) &&
                  !(pair && ((rd % 2) == 1 || (rs2 % 2) == 1));         // R1 R3
        nb      = size_of(c);
        aligned = (nb != 0) && ((a % nb) == 0);
        cmpv = opnd(rd, c, m32, pair);
        swpv = opnd(rs2, c, m32, pair);
        if (force_match && legal && aligned)
            for (int i = 0; i < nb; i++) mem_m[a + i] = cmpv[8*i +: 8];
        for (int k = 0; k < 64; k++) exp_mem[k] = mem_m[k];
        for (int r = 0; r < 32; r++) exp_rf[r] = rf_m[r];
        oldv = '0;
        for (int i = 0; i < nb; i++) oldv[8*i +: 8] = mem_m[(a + i) % 64];
        hit = (oldv == cmpv);
        if (legal && aligned) begin
            if (hit) for (int i = 0; i < nb; i++) exp_mem[a + i] = swpv[8*i +: 8]; // R7
            if (rd != 0) begin                                           // R8
                if (pair && m32) begin
                    exp_rf[rd] = sx(oldv[31:0]); exp_rf[rd+1] = sx(oldv[63:32]); // R9
                end else if (pair) begin
                    exp_rf[rd] = oldv[63:0]; exp_rf[rd+1] = oldv[127:64];
                end else if (c == 2'd0) exp_rf[rd] = sx(oldv[31:0]);
                else exp_rf[rd] = oldv[63:0];
            end
            lat_exp = 5 + (hit ? 1 : 0) + (pair ? 2 : 0);
        end else lat_exp = 2;
        acc_cnt = 0; wr_rf_cnt = 0; lock_bad = 0;
        @(negedge clk);
        width_code = c; mode32 = m32; rd_idx = 5'(rd); rs2_idx = 5'(rs2);
        addr = 32'(a); start = 1'b1;
        n = 0; got = 0; ill_s = 0; mis_s = 0;
        while (n < 40 && !got) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            n++;
            apply_effects();
            if (done) begin got = 1; ill_s = err_illegal; mis_s = err_misalign; end
        end
        chk(got && n == lat_exp, "R11", "cycles to done", 128'(n), 128'(lat_exp));
        chk(ill_s == !legal, "R3", "illegal flag", 128'(ill_s), 128'(!legal));
        chk(mis_s == (legal && !aligned), "R6", "misalign flag", 128'(mis_s), 128'(legal && !aligned));
        if (!(legal && aligned))
            chk(acc_cnt == 0 && wr_rf_cnt == 0, "R3", "fault side effects",
                128'(acc_cnt + wr_rf_cnt), 128'(0));
        chk(lock_bad == 0, "R10", "unlocked write", 128'(lock_bad), 128'(0));
        bad_b = -1;
        for (int k = 0; k < 64; k++) if (bad_b < 0 && mem_m[k] !== exp_mem[k]) bad_b = k;
        chk(bad_b < 0, "R7", "memory image (R1 size)",
            (bad_b < 0) ? 128'(0) : 128'(mem_m[bad_b]), (bad_b < 0) ? 128'(0) : 128'(exp_mem[bad_b]));
        bad_r = -1;
        for (int r = 1; r < 32; r++) if (bad_r < 0 && rf_m[r] !== exp_rf[r]) bad_r = r;
        chk(bad_r < 0, "R9", "register image",
            (bad_r < 0) ? 128'(0) : 128'(rf_m[bad_r]), (bad_r < 0) ? 128'(0) : 128'(exp_rf[bad_r]));
        chk(rf_m[0] === x0_before, "R8", "index 0 unwritten", 128'(rf_m[0]), 128'(x0_before));
    endtask

    typedef struct packed {
        logic [1:0] code;
        logic       m32;
        logic [4:0] rd;
        logic [4:0] rs2;
        logic [5:0] addr;
        logic       match;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 5'd4,  5'd6,  6'd8,  1'b1}, // R1 word hit, R9 sign extension
        '{2'd0, 1'b0, 5'd4,  5'd6,  6'd8,  1'b0}, // R7 word miss
        '{2'd1, 1'b0, 5'd5,  5'd7,  6'd16, 1'b1}, // R2 8 bytes single reg, odd fine
        '{2'd1, 1'b1, 5'd10, 5'd12, 6'd24, 1'b1}, // R2 R5 pair in 32-bit mode
        '{2'd1, 1'b1, 5'd10, 5'd12, 6'd24, 1'b0}, // R9 miss, halves sign-extended
        '{2'd2, 1'b0, 5'd8,  5'd14, 6'd32, 1'b1}, // R5 16-byte pair hit
        '{2'd2, 1'b0, 5'd8,  5'd0,  6'd48, 1'b1}, // R4 swap from index 0 pair
        '{2'd2, 1'b0, 5'd0,  5'd2,  6'd16, 1'b1}, // R4 R8 compare zero, no writeback
        '{2'd2, 1'b0, 5'd3,  5'd2,  6'd16, 1'b1}, // R3 odd rd
        '{2'd1, 1'b1, 5'd4,  5'd9,  6'd0,  1'b1}, // R3 odd rs2
        '{2'd2, 1'b1, 5'd4,  5'd6,  6'd0,  1'b1}, // R2 16 bytes in 32-bit mode
        '{2'd3, 1'b0, 5'd4,  5'd6,  6'd0,  1'b1}, // R1 reserved width code
        '{2'd1, 1'b0, 5'd4,  5'd6,  6'd4,  1'b1}, // R6 8-byte misaligned
        '{2'd2, 1'b0, 5'd4,  5'd6,  6'd8,  1'b1}, // R6 16-byte misaligned
        '{2'd0, 1'b1, 5'd2,  5'd3,  6'd2,  1'b1}, // R6 4-byte misaligned
        '{2'd2, 1'b0, 5'd3,  5'd6,  6'd3,  1'b1}, // R6 illegal wins over misalign
        '{2'd0, 1'b1, 5'd0,  5'd3,  6'd12, 1'b1}  // R8 word, rd 0, 32-bit mode
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] snap [64];
        int guard;
        preload();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!done && !rf_we && !mem_req && !mem_lock, "R12", "outputs in reset",
            {done, rf_we, mem_req, mem_lock}, 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rf_we && !mem_req && !mem_lock, "R12", "outputs after reset",
            {done, rf_we, mem_req, mem_lock}, 128'(0));

        for (int v = 0; v < NV; v++)
            run_case(VECS[v].code, VECS[v].m32, int'(VECS[v].rd), int'(VECS[v].rs2),
                     int'(VECS[v].addr), VECS[v].match);

        // R12 reset during the locked read abandons the operation
        preload();
        for (int k = 0; k < 64; k++) snap[k] = mem_m[k];
        @(negedge clk);
        width_code = 2'd2; mode32 = 1'b0; rd_idx = 5'd0; rs2_idx = 5'd2;
        addr = 32'd16; start = 1'b1;
        guard = 0;
        while (!(mem_req && !mem_we) && guard < 20) begin
            @(posedge clk); @(negedge clk); start = 1'b0; guard++;
        end
        chk(mem_lock, "R10", "lock during read", 128'(mem_lock), 128'(1));
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!done && !rf_we && !mem_req && !mem_lock, "R12", "outputs after abort",
            {done, rf_we, mem_req, mem_lock}, 128'(0));
        guard = 0;
        for (int k = 0; k < 64; k++) if (mem_m[k] !== snap[k]) guard++;
        chk(guard == 0, "R12", "memory after abort", 128'(guard), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        run_case(2'd1, 1'b1, 10, 12, 24, 1'b1); // R12 recovery after abort

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule